// File: doc/BRIEF.md
# Summary interrupt aggregator

This block gathers a small number of level-sensitive event inputs into a single interrupt line for a host processor. Every input has a sticky pending flag and an enable flag. The summary line is raised while at least one input is both pending and enabled. Software services an input by writing 1 to its pending flag, and it masks or unmasks an input through its enable flag.

A build-time parameter picks one of two register layouts. In the merged layout, enables and pending flags share one 32-bit word at offset 0x00. Pending flags sit exactly 16 bits above their enables, and they are write-1-to-clear. Software can therefore rewrite the enables with zeros in the pending positions without losing pending events. In the separate layout, enables and pending flags each have their own word; a parameter chooses which of the two sits at 0x00 and which at 0x04. In both layouts the served inputs may start at a nonzero bit offset.

The register port is a plain single-cycle port. A write takes effect at the clock edge where the write strobe is high. Read data is a combinational function of the address and the current register state.

Top module: `irq_gather`

## Requirements
- R1: In the merged layout (LAYOUT_MERGED), input k has its enable at bit SRC_BASE+k and its pending flag at bit SRC_BASE+k+16 of the word at byte address 0x00. SRC_BASE+NUM_SRC must not exceed 13.
- R2: A pending flag is set at every clock edge where its input is high. It stays set after the input falls, until software clears it.
- R3: Writing 1 to a pending position clears that flag, and writing 0 leaves it unchanged. In the merged layout, a write updates all enables from the same word; pending flags written as 0 keep their value.
- R4: When an input is high in the same cycle as a write-1 clear of its flag, the flag stays set.
- R5: irq_o is a register. It is high in the cycle after the one in which some input was both pending and enabled, and it is low otherwise.
- R6: A pending but disabled input does not raise irq_o. Enabling it later raises irq_o one cycle after the enable write lands.
- R7: In the separate layout (LAYOUT_SEPARATE), input k uses bit SRC_BASE+k of both words. The enable word is at 0x00 and the pending word at 0x04 when EN_AT_ZERO=1; when EN_AT_ZERO=0 the two are swapped. A write to the enable word replaces all enables and leaves pending flags alone.
- R8: Register bits that map no input read as 0, and writes to them have no effect. Any address other than the mapped word(s) reads as 0 and changes nothing.
- R9: Reset clears all enables, all pending flags and irq_o.
- R10: With a nonzero SRC_BASE, input 0 maps to bit SRC_BASE of each field, and the bits below it are unused.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| src_i | input | NUM_SRC | Level-sensitive event inputs |
| reg_addr_i | input | ADDR_W | Byte address of the register access |
| reg_we_i | input | 1 | Write strobe, sampled at the rising edge |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |
| irq_o | output | 1 | Registered summary interrupt |

## Verification
An input that is high at one edge and a write strobed at one edge both show up in the read data immediately after that edge, because the read path has no register. The summary line needs one more edge. The bench drives stimulus on falling edges and reads back registers at the first falling edge after the write or input edge. It checks irq_o both at that same falling edge, where it must still hold the old value, and one falling edge later, where the new value is due. This pins the one-cycle lag of R5 and R6 exactly. The same-edge case, where an input is high and its flag is cleared in one cycle, is driven inside a single cycle so that R4 is tested at the exact edge where the two collide.

// File: rtl/irq_gather_pkg.sv
package irq_gather_pkg;

    typedef enum logic {
        LAYOUT_MERGED   = 1'b0,
        LAYOUT_SEPARATE = 1'b1
    } layout_e;

    // distance between an enable bit and its pending bit in the merged word
    localparam int unsigned PEND_SHIFT      = 16;
    // highest number of bit positions usable by the merged pending field
    localparam int unsigned MERGED_MAX_BITS = 13;
    localparam int unsigned DATA_W          = 32;

endpackage

// File: rtl/irq_gather_src_cell.sv
module irq_gather_src_cell (
    input  logic src_i,
    input  logic clr_i,
    input  logic pend_q_i,
    output logic pend_d_o
);

    // a live input wins over a clear arriving in the same cycle
    always_comb begin
        pend_d_o = (pend_q_i & ~clr_i) | src_i;
    end

endmodule

// File: rtl/irq_gather_decode.sv
module irq_gather_decode
    import irq_gather_pkg::*;
#(
    parameter int unsigned NUM_SRC    = 4,
    parameter int unsigned SRC_BASE   = 0,
    parameter layout_e     LAYOUT     = LAYOUT_MERGED,
    parameter bit          EN_AT_ZERO = 1'b1,
    parameter int unsigned ADDR_W     = 8
) (
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               we_i,
    input  logic [DATA_W-1:0]  wdata_i,
    input  logic [NUM_SRC-1:0] en_q_i,
    input  logic [NUM_SRC-1:0] pend_q_i,
    output logic               en_wr_o,
    output logic [NUM_SRC-1:0] en_wval_o,
    output logic [NUM_SRC-1:0] pend_clr_o,
    output logic [DATA_W-1:0]  rdata_o
);

    localparam logic [ADDR_W-1:0] ADDR_LO  = '0;
    localparam logic [ADDR_W-1:0] ADDR_HI  = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] EN_ADDR  = EN_AT_ZERO ? ADDR_LO : ADDR_HI;
    localparam logic [ADDR_W-1:0] PND_ADDR = EN_AT_ZERO ? ADDR_HI : ADDR_LO;

    logic unused_wdata;
    assign unused_wdata = ^wdata_i;

    generate
        if (LAYOUT == LAYOUT_MERGED) begin : g_merged
            logic hit;
            assign hit = (addr_i == ADDR_LO);

            always_comb begin
                en_wr_o = we_i & hit;
                rdata_o = '0;
                for (int k = 0; k < NUM_SRC; k++) begin
                    en_wval_o[k]  = wdata_i[SRC_BASE + k];
                    pend_clr_o[k] = we_i & hit & wdata_i[SRC_BASE + k + PEND_SHIFT];
                    if (hit) begin
                        rdata_o[SRC_BASE + k]              = en_q_i[k];
                        rdata_o[SRC_BASE + k + PEND_SHIFT] = pend_q_i[k];
                    end
                end
            end
        end else begin : g_separate
            logic en_hit;
            logic pnd_hit;
            assign en_hit  = (addr_i == EN_ADDR);
            assign pnd_hit = (addr_i == PND_ADDR);

            always_comb begin
                en_wr_o = we_i & en_hit;
                rdata_o = '0;
                for (int k = 0; k < NUM_SRC; k++) begin
                    en_wval_o[k]  = wdata_i[SRC_BASE + k];
                    pend_clr_o[k] = we_i & pnd_hit & wdata_i[SRC_BASE + k];
                    if (en_hit) begin
                        rdata_o[SRC_BASE + k] = en_q_i[k];
                    end else if (pnd_hit) begin
                        rdata_o[SRC_BASE + k] = pend_q_i[k];
                    end
                end
            end
        end
    endgenerate

endmodule

// File: rtl/irq_gather.sv
module irq_gather
    import irq_gather_pkg::*;
#(
    parameter int unsigned NUM_SRC    = 4,
    parameter int unsigned SRC_BASE   = 0,
    parameter layout_e     LAYOUT     = LAYOUT_MERGED,
    parameter bit          EN_AT_ZERO = 1'b1,
    parameter int unsigned ADDR_W     = 8
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [ADDR_W-1:0]  reg_addr_i,
    input  logic               reg_we_i,
    input  logic [DATA_W-1:0]  reg_wdata_i,
    output logic [DATA_W-1:0]  reg_rdata_o,
    output logic               irq_o
);

    typedef struct packed {
        logic [NUM_SRC-1:0] en;
        logic [NUM_SRC-1:0] pend;
        logic               irq;
    } state_t;

    state_t state_d, state_q;

    logic               en_wr;
    logic [NUM_SRC-1:0] en_wval;
    logic [NUM_SRC-1:0] pend_clr;
    logic [NUM_SRC-1:0] pend_next;

    irq_gather_decode #(
        .NUM_SRC    (NUM_SRC),
        .SRC_BASE   (SRC_BASE),
        .LAYOUT     (LAYOUT),
        .EN_AT_ZERO (EN_AT_ZERO),
        .ADDR_W     (ADDR_W)
    ) u_decode (
        .addr_i     (reg_addr_i),
        .we_i       (reg_we_i),
        .wdata_i    (reg_wdata_i),
        .en_q_i     (state_q.en),
        .pend_q_i   (state_q.pend),
        .en_wr_o    (en_wr),
        .en_wval_o  (en_wval),
        .pend_clr_o (pend_clr),
        .rdata_o    (reg_rdata_o)
    );

    generate
        for (genvar k = 0; k < NUM_SRC; k++) begin : g_cell
            irq_gather_src_cell u_cell (
                .src_i    (src_i[k]),
                .clr_i    (pend_clr[k]),
                .pend_q_i (state_q.pend[k]),
                .pend_d_o (pend_next[k])
            );
        end
    endgenerate

    always_comb begin
        state_d      = state_q;
        state_d.pend = pend_next;
        if (en_wr) begin
            state_d.en = en_wval;
        end
        state_d.irq = |(state_q.en & state_q.pend);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign irq_o = state_q.irq;

endmodule

// File: rtl/irq_gather_chk.sv
module irq_gather_chk
    import irq_gather_pkg::*;
#(
    parameter int unsigned NUM_SRC  = 4,
    parameter int unsigned SRC_BASE = 0,
    parameter layout_e     LAYOUT   = LAYOUT_MERGED
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] src,
    input logic               we,
    input logic [DATA_W-1:0]  rdata,
    input logic               irq,
    input logic [NUM_SRC-1:0] en,
    input logic [NUM_SRC-1:0] pend
);

    localparam logic [DATA_W-1:0] FIELD = ((DATA_W'(1) << NUM_SRC) - 1) << SRC_BASE;
    localparam logic [DATA_W-1:0] LEGAL = (LAYOUT == LAYOUT_MERGED)
                                          ? (FIELD | (FIELD << PEND_SHIFT)) : FIELD;

    // R2 / R4: an input high at an edge leaves its flag set, even under a clear
    a_r4_src_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend & $past(src)) == $past(src)));

    // R2: without a write no flag can drop
    a_r2_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> ((pend & $past(pend)) == $past(pend)));

    // R3: enables change only through a write
    a_r3_en_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(en));

    // R5 / R6: summary follows pending-and-enabled one cycle later
    a_r5_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (|(en & pend)) |=> irq);

    a_r6_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(en & pend)) |=> !irq);

    // R8: unmapped bit positions always read as zero
    a_r8_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata & ~LEGAL) == '0);

endmodule

bind irq_gather irq_gather_chk #(
    .NUM_SRC  (NUM_SRC),
    .SRC_BASE (SRC_BASE),
    .LAYOUT   (LAYOUT)
) u_chk (
    .clk   (clk_i),
    .rst_n (rst_ni),
    .src   (src_i),
    .we    (reg_we_i),
    .rdata (reg_rdata_o),
    .irq   (irq_o),
    .en    (state_q.en),
    .pend  (state_q.pend)
);

// File: tb/irq_gather_tb.sv
module irq_gather_tb;
    import irq_gather_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    // merged layout: 3 inputs starting at bit 2
    logic [2:0]  c_src = '0;
    logic [7:0]  c_addr = '0;
    logic        c_we = 1'b0;
    logic [31:0] c_wdata = '0;
    logic [31:0] c_rdata;
    logic        c_irq;

    // separate layout: 4 inputs at bit 0, pending word at 0x00, enables at 0x04
    logic [3:0]  s_src = '0;
    logic [7:0]  s_addr = '0;
    logic        s_we = 1'b0;
    logic [31:0] s_wdata = '0;
    logic [31:0] s_rdata;
    logic        s_irq;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    irq_gather #(.NUM_SRC(3), .SRC_BASE(2), .LAYOUT(LAYOUT_MERGED), .EN_AT_ZERO(1'b1), .ADDR_W(8)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .src_i(c_src), .reg_addr_i(c_addr), .reg_we_i(c_we),
        .reg_wdata_i(c_wdata), .reg_rdata_o(c_rdata), .irq_o(c_irq));

    irq_gather #(.NUM_SRC(4), .SRC_BASE(0), .LAYOUT(LAYOUT_SEPARATE), .EN_AT_ZERO(1'b0), .ADDR_W(8)) u_sep (
        .clk_i(clk), .rst_ni(rst_n), .src_i(s_src), .reg_addr_i(s_addr), .reg_we_i(s_we),
        .reg_wdata_i(s_wdata), .reg_rdata_o(s_rdata), .irq_o(s_irq));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic c_read(input string tag, input logic [7:0] a, input logic [31:0] exp);
        c_addr = a; #1;
        check(tag, c_rdata, exp);
        c_addr = '0;
    endtask

    task automatic s_read(input string tag, input logic [7:0] a, input logic [31:0] exp);
        s_addr = a; #1;
        check(tag, s_rdata, exp);
    endtask

    // ends at the falling edge right after the write edge
    task automatic c_write(input logic [31:0] d);
        @(negedge clk); c_addr = '0; c_wdata = d; c_we = 1'b1;
        @(negedge clk); c_we = 1'b0;
    endtask

    task automatic s_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); s_addr = a; s_wdata = d; s_we = 1'b1;
        @(negedge clk); s_we = 1'b0;
    endtask

    task automatic c_pulse(input logic [2:0] m);
        @(negedge clk); c_src = m;
        @(negedge clk); c_src = '0;
    endtask

    task automatic s_pulse(input logic [3:0] m);
        @(negedge clk); s_src = m;
        @(negedge clk); s_src = '0;
    endtask

    task automatic t_reset();
        c_read("R9 merged word after reset", 8'h00, 32'h0);
        check("R9 merged irq after reset", {31'b0, c_irq}, 32'h0);
        s_read("R9 pending word after reset", 8'h00, 32'h0);
        s_read("R9 enable word after reset", 8'h04, 32'h0);
        check("R9 separate irq after reset", {31'b0, s_irq}, 32'h0);
    endtask

    task automatic t_merged_map();
        c_pulse(3'b010);
        c_read("R1 R10 R2 input 1 flag at bit 19", 8'h00, 32'h0008_0000);
        @(negedge clk);
        check("R6 disabled flag keeps irq low", {31'b0, c_irq}, 32'h0);
    endtask

    task automatic t_enable();
        c_write(32'h0000_0008);
        c_read("R3 enable write keeps pending", 8'h00, 32'h0008_0008);
        check("R5 irq not yet on write edge", {31'b0, c_irq}, 32'h0);
        @(negedge clk);
        check("R6 R5 irq one cycle after enable", {31'b0, c_irq}, 32'h1);
    endtask

    task automatic t_clear();
        c_write(32'h0008_0008);
        c_read("R3 write-1 clears flag", 8'h00, 32'h0000_0008);
        check("R5 irq holds on clear edge", {31'b0, c_irq}, 32'h1);
        @(negedge clk);
        check("R5 irq drops one cycle after clear", {31'b0, c_irq}, 32'h0);
    endtask

    task automatic t_unused();
        c_pulse(3'b100);
        c_write(32'hFFE3_FFE3);
        c_read("R8 writes to unused bits ignored", 8'h00, 32'h0010_0000);
        c_read("R8 unmapped address reads zero", 8'h04, 32'h0);
        c_write(32'hFFFF_FFFF);
        c_read("R8 R3 all-ones write", 8'h00, 32'h0000_001C);
    endtask

    task automatic t_set_wins();
        @(negedge clk);
        c_src = 3'b001; c_addr = '0; c_wdata = 32'h0004_001C; c_we = 1'b1;
        @(negedge clk);
        c_src = '0; c_we = 1'b0;
        c_read("R4 set beats same-cycle clear", 8'h00, 32'h0004_001C);
        @(negedge clk);
        check("R5 irq after collision", {31'b0, c_irq}, 32'h1);
        c_write(32'h0004_001C);
        c_read("R3 later clear succeeds", 8'h00, 32'h0000_001C);
        @(negedge clk);
        check("R5 irq low after clear", {31'b0, c_irq}, 32'h0);
    endtask

    task automatic t_separate();
        s_pulse(4'b0101);
        s_read("R7 pending word at 0x00", 8'h00, 32'h5);
        s_read("R7 enable word at 0x04 still zero", 8'h04, 32'h0);
        check("R6 separate irq low while masked", {31'b0, s_irq}, 32'h0);
        s_write(8'h04, 32'h4);
        s_read("R7 enable word written", 8'h04, 32'h4);
        s_read("R7 enable write leaves pending", 8'h00, 32'h5);
        @(negedge clk);
        check("R5 separate irq rises", {31'b0, s_irq}, 32'h1);
        s_write(8'h00, 32'h4);
        s_read("R3 separate write-1 clear", 8'h00, 32'h1);
        @(negedge clk);
        check("R6 masked leftover flag keeps irq low", {31'b0, s_irq}, 32'h0);
        s_write(8'h04, 32'hFFFF_FFFF);
        s_read("R8 separate upper enable bits ignored", 8'h04, 32'hF);
        @(negedge clk);
        check("R5 separate irq after enable all", {31'b0, s_irq}, 32'h1);
        s_write(8'h00, 32'hFFFF_FFFF);
        s_read("R3 separate clear all", 8'h00, 32'h0);
        s_read("R8 separate unmapped address", 8'h08, 32'h0);
        @(negedge clk);
        check("R5 separate irq low at end", {31'b0, s_irq}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_merged_map();
        t_enable();
        t_clear();
        t_unused();
        t_set_wins();
        t_separate();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule